// File: doc/BRIEF.md
# Bit-serial HDLC receive framer with address filter

The block takes a serial bit stream, qualified by a per-bit strobe, and rebuilds HDLC frames from it. It hunts for the flag octet 0x7E, strips the zero that a transmitter inserts after five ones, and runs every frame bit through a CRC-16 checker. At the closing flag it checks the residue and whether a whole number of octets arrived. The first two octets of each frame form an address. Four programmable slots can compare against it, and only matching frames are kept when filtering is switched on.

Accepted octets go into a receive queue that holds 32 entries. The queue marks the final octet of every frame, and a frame becomes readable only once its closing flag has arrived. A frame that aborts or overflows the queue is rolled back out of it. Six sticky event bits and a fill threshold feed one maskable interrupt line. The host pulls octets one at a time through a show-ahead read port.

Top module: `hdlc_rx_filter`

## Requirements
- R1: A flag (0x7E, sent least significant bit first) opens a frame. The next flag closes it and also opens the following frame. Flags with no data bits between them produce nothing.
- R2: Inside a frame, a 0 that follows five consecutive 1s is deleted. It never appears in stored octets.
- R3: The CRC (x^16+x^12+x^5+1, preset 0xFFFF, reflected) covers every data bit, the two FCS octets included. When the octet count is whole and the final residue is not 0xF0B8, event bit 2 (FCS error) sets.
- R4: When the number of data bits between the flags is not a multiple of 8, event bit 1 (partial octet) sets. The complete octets are still stored.
- R5: Seven consecutive 1s after data bits have started set event bit 0 (abort), and the partial frame is removed from the queue. Idle 1s that follow a closing flag raise no abort.
- R6: With filtering on, a frame is stored only when {octet1, octet0} equals an enabled slot (slot i occupies slot_addr[16i+15:16i]). On a match, event bit 5 sets and hit_slot takes the lowest matching index.
- R7: With filtering off, every frame is stored, and event bit 5 (end of address) sets once the second octet has arrived.
- R8: Stored entries keep arrival order and include both FCS octets. rd_last marks the final octet. A frame's octets become visible in rd_count only after its closing flag.
- R9: With irq_en[6] set and fifo_thresh nonzero, irq is high while rd_count >= fifo_thresh.
- R10: When a later octet of an accepted frame meets a full queue, event bit 3 (overflow) sets and the whole frame is discarded.
- R11: When an accepted frame's first write meets a full queue, event bit 4 (frame lost) sets. Nothing from that frame is stored, and the earlier content is kept.
- R12: Event bits are sticky and clear on an ev_rd pulse. irq is the OR of ev_flags[i] & irq_en[i] over i = 0 to 5, together with the threshold term.
- R13: After reset, the queue is empty, ev_flags is 0, hit_slot is 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial line bit |
| rx_valid | input | 1 | rx_bit is valid this cycle |
| addr_dec_en | input | 1 | Enable address filtering |
| slot_en | input | 4 | Per-slot enable |
| slot_addr | input | 64 | Four 16-bit addresses, {octet1, octet0} each |
| fifo_thresh | input | 6 | Fill level for the threshold interrupt, 0 turns it off |
| irq_en | input | 7 | Interrupt enables: bits 0-5 for events, bit 6 for threshold |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head octet |
| rd_last | output | 1 | Head octet ends a frame |
| rd_count | output | 6 | Readable entries |
| byte_avail | output | 1 | At least one readable entry |
| ev_rd | input | 1 | Read-clear pulse for event bits |
| ev_flags | output | 6 | Sticky event bits |
| hit_slot | output | 2 | Index of the last matching slot |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties watch, on every cycle, that the queue is never written while full, that the visible count moves only on commit or pop, that an abort leaves the visible count unchanged, that every first write passed the address gate, and that event bits clear after a read. Only the bench scenarios can show that stuffed zeros vanish, that the CRC residue and the partial-octet rule judge real frames correctly, that slot priority holds, and that overflow and lost frames leave exactly the right bytes in the queue.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  localparam int NUM_EV    = 6;
  localparam int EV_ABORT  = 0;
  localparam int EV_NONINT = 1;
  localparam int EV_FCS    = 2;
  localparam int EV_OVF    = 3;
  localparam int EV_LOST   = 4;
  localparam int EV_ADDR   = 5;

  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } rx_ent_t;

  // one reflected CRC-16 step, least significant bit of the line first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic [15:0] sh;
    sh = c >> 1;
    return (c[0] ^ b) ? (sh ^ CRC_POLY_R) : sh;
  endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_valid,
  output logic dat_vld,
  output logic dat_bit,
  output logic flag_seen,
  output logic abort_seen
);
  localparam int HOLD = 7;

  logic [2:0]      ones_q, ones_n;
  logic [HOLD-1:0] hold_q;
  logic [2:0]      held_q;
  logic            push, pbit, flag_n, abort_n;

  always_comb begin
    push = 1'b0; pbit = 1'b0; flag_n = 1'b0; abort_n = 1'b0; ones_n = ones_q;
    if (rx_valid) begin
      if (rx_bit) begin
        if (ones_q == 3'd6) begin
          abort_n = 1'b1; ones_n = 3'd7;
        end else if (ones_q != 3'd7) begin
          ones_n = ones_q + 3'd1; push = 1'b1; pbit = 1'b1;
        end
      end else begin
        ones_n = 3'd0;
        if (ones_q == 3'd6)      flag_n = 1'b1;
        else if (ones_q != 3'd5) push   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 3'd7; hold_q <= '0; held_q <= '0;
      dat_vld <= 1'b0; dat_bit <= 1'b0; flag_seen <= 1'b0; abort_seen <= 1'b0;
    end else begin
      ones_q     <= ones_n;
      flag_seen  <= flag_n;
      abort_seen <= abort_n;
      dat_vld    <= push && (held_q == 3'(HOLD));
      dat_bit    <= hold_q[0];
      if (flag_n || abort_n) begin
        held_q <= '0;
      end else if (push) begin
        if (held_q == 3'(HOLD)) hold_q <= {pbit, hold_q[HOLD-1:1]};
        else begin
          hold_q[held_q[2:0]] <= pbit;
          held_q <= held_q + 3'd1;
        end
      end
    end
  end

  // R5
  abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_seen |=> !abort_seen);
  // R1
  flag_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_seen |=> !dat_vld);

endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match #(
  parameter int NUM_SLOTS = 4,
  parameter int SIW       = 2
) (
  input  logic [15:0]             cand,
  input  logic [16*NUM_SLOTS-1:0] slot_tbl,
  input  logic [NUM_SLOTS-1:0]    slot_en,
  output logic                    hit,
  output logic [SIW-1:0]          idx
);
  logic [NUM_SLOTS-1:0] eq;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign eq[g] = slot_en[g] && (slot_tbl[16*g +: 16] == cand);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (eq[i]) idx = i[SIW-1:0];
  end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  rx_ent_t push_ent,
  input  logic    commit,
  input  logic    rollback,
  input  logic    pop,
  output logic    full,
  output logic [CW-1:0] vis,
  output rx_ent_t head
);
  rx_ent_t       mem [DEPTH];
  logic [CW-1:0] wr_q, cm_q, rd_q;
  logic          pop_ok;

  assign full   = (wr_q - rd_q) == CW'(DEPTH);
  assign vis    = cm_q - rd_q;
  assign head   = mem[rd_q[AW-1:0]];
  assign pop_ok = pop && (vis != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; cm_q <= '0; rd_q <= '0;
    end else begin
      if (rollback)  wr_q <= cm_q;
      else if (push) wr_q <= wr_q + CW'(1);
      if (commit)    cm_q <= wr_q + CW'(push);
      if (pop_ok)    rd_q <= rd_q + CW'(1);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !pop) |=> $stable(vis));

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int NUM_SLOTS = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = AW + 1,
  localparam int SIW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_bit,
  input  logic                    rx_valid,
  input  logic                    addr_dec_en,
  input  logic [NUM_SLOTS-1:0]    slot_en,
  input  logic [16*NUM_SLOTS-1:0] slot_addr,
  input  logic [CW-1:0]           fifo_thresh,
  input  logic [NUM_EV:0]         irq_en,
  input  logic                    rd_en,
  output logic [7:0]              rd_data,
  output logic                    rd_last,
  output logic [CW-1:0]           rd_count,
  output logic                    byte_avail,
  input  logic                    ev_rd,
  output logic [NUM_EV-1:0]       ev_flags,
  output logic [SIW-1:0]          hit_slot,
  output logic                    irq
);
  // deframer events, brought out as named wires
  logic dat_vld, dat_bit, flag_seen, abort_seen;

  hdlc_rx_deframer u_deframer (
    .clk, .rst_n, .rx_bit, .rx_valid,
    .dat_vld, .dat_bit, .flag_seen, .abort_seen
  );

  logic        in_frame_q, keep_q;
  logic [2:0]  bcnt_q;
  logic [1:0]  nbytes_q;
  logic [7:0]  sr_q, b0_q, stg_q;
  logic [15:0] crc_q;
  logic [NUM_EV-1:0] ev_q, ev_set;

  logic [7:0] new_byte;
  logic any_bits, closing, frame_abort, byte_done;
  logic addr_hit, addr_ok;
  logic [SIW-1:0] addr_idx;

  logic    fifo_full, push, commit, rollback;
  rx_ent_t push_ent, head;
  logic [CW-1:0] vis;

  assign new_byte    = {dat_bit, sr_q[7:1]};
  assign any_bits    = (bcnt_q != 3'd0) || (nbytes_q != 2'd0);
  assign closing     = flag_seen && in_frame_q && any_bits;
  assign frame_abort = abort_seen && in_frame_q && any_bits;
  assign byte_done   = dat_vld && in_frame_q && (bcnt_q == 3'd7);

  hdlc_rx_addr_match #(.NUM_SLOTS(NUM_SLOTS), .SIW(SIW)) u_match (
    .cand({new_byte, b0_q}), .slot_tbl(slot_addr), .slot_en(slot_en),
    .hit(addr_hit), .idx(addr_idx)
  );

  assign addr_ok = addr_hit || !addr_dec_en;

  always_comb begin
    push = 1'b0; commit = 1'b0; rollback = 1'b0;
    push_ent = '0; ev_set = '0;
    if (closing) begin
      ev_set[EV_NONINT] = (bcnt_q != 3'd0);
      ev_set[EV_FCS]    = (bcnt_q == 3'd0) && (crc_q != CRC_GOOD);
      if (keep_q) begin
        if (fifo_full) begin
          ev_set[EV_OVF] = 1'b1; rollback = 1'b1;
        end else begin
          push = 1'b1; commit = 1'b1;
          push_ent = '{last: 1'b1, data: stg_q};
        end
      end
    end
    if (frame_abort) begin
      ev_set[EV_ABORT] = 1'b1; rollback = 1'b1;
    end
    if (byte_done) begin
      if (nbytes_q == 2'd1) begin
        ev_set[EV_ADDR] = addr_ok;
        if (addr_ok) begin
          if (fifo_full) ev_set[EV_LOST] = 1'b1;
          else begin
            push = 1'b1; push_ent = '{last: 1'b0, data: b0_q};
          end
        end
      end else if (nbytes_q == 2'd2 && keep_q) begin
        if (fifo_full) begin
          ev_set[EV_OVF] = 1'b1; rollback = 1'b1;
        end else begin
          push = 1'b1; push_ent = '{last: 1'b0, data: stg_q};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0; keep_q <= 1'b0; bcnt_q <= '0; nbytes_q <= '0;
      sr_q <= '0; b0_q <= '0; stg_q <= '0; crc_q <= CRC_PRESET;
      ev_q <= '0; hit_slot <= '0;
    end else begin
      ev_q <= (ev_q & ~{NUM_EV{ev_rd}}) | ev_set;
      if (flag_seen) begin
        in_frame_q <= 1'b1; keep_q <= 1'b0;
        bcnt_q <= '0; nbytes_q <= '0; crc_q <= CRC_PRESET;
      end else if (abort_seen) begin
        in_frame_q <= 1'b0; keep_q <= 1'b0;
      end else if (dat_vld && in_frame_q) begin
        crc_q  <= crc16_step(crc_q, dat_bit);
        sr_q   <= new_byte;
        bcnt_q <= bcnt_q + 3'd1;
        if (byte_done) begin
          case (nbytes_q)
            2'd0: begin
              b0_q <= new_byte; nbytes_q <= 2'd1;
            end
            2'd1: begin
              nbytes_q <= 2'd2; stg_q <= new_byte;
              keep_q   <= addr_ok && !fifo_full;
              if (addr_hit && addr_dec_en) hit_slot <= addr_idx;
            end
            default: begin
              if (keep_q && fifo_full) keep_q <= 1'b0;
              else                     stg_q  <= new_byte;
            end
          endcase
        end
      end
    end
  end

  hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .push, .push_ent, .commit, .rollback,
    .pop(rd_en), .full(fifo_full), .vis, .head
  );

  logic thr_hit;
  assign rd_data    = head.data;
  assign rd_last    = head.last;
  assign rd_count   = vis;
  assign byte_avail = (vis != '0);
  assign ev_flags   = ev_q;
  assign thr_hit    = (fifo_thresh != '0) && (vis >= fifo_thresh);
  assign irq        = |(ev_q & irq_en[NUM_EV-1:0]) | (irq_en[NUM_EV] & thr_hit);

  // R12
  ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> ((ev_q & ~$past(ev_set)) == '0));
  // R6
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && byte_done && nbytes_q == 2'd1) |-> (addr_hit || !addr_dec_en));
  // R5
  abort_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_abort && !rd_en) |=> $stable(rd_count));
  // R8
  last_only_closing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_ent.last) |-> closing);

endmodule

// File: tb/hdlc_rx_filter_bench.sv
module hdlc_rx_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, rx_valid = 1'b0;
  logic addr_dec_en = 1'b0;
  logic [3:0]  slot_en = '0;
  logic [63:0] slot_addr = '0;
  logic [5:0]  fifo_thresh = '0;
  logic [6:0]  irq_en = '0;
  logic rd_en = 1'b0, ev_rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_last, byte_avail, irq;
  logic [5:0] rd_count, ev_flags;
  logic [1:0] hit_slot;

  hdlc_rx_filter u_hdlc_rx_filter (
    .clk, .rst_n, .rx_bit, .rx_valid, .addr_dec_en, .slot_en, .slot_addr,
    .fifo_thresh, .irq_en, .rd_en, .rd_data, .rd_last, .rd_count,
    .byte_avail, .ev_rd, .ev_flags, .hit_slot, .irq
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_errors = 0;
  logic [8:0] exp_q[$];
  logic mon_en = 1'b1;
  int tx_ones = 0;
  logic [15:0] tx_crc;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops and compares as entries become readable
  always @(negedge clk) begin
    rd_en = 1'b0;
    if (mon_en && byte_avail && rst_n) begin
      logic [8:0] e;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R8: actual=%0h expected=none", {rd_last, rd_data});
      end else begin
        e = exp_q.pop_front();
        if ({rd_last, rd_data} !== e) begin
          n_errors++;
          $display("FAIL R8: actual=%0h expected=%0h", {rd_last, rd_data}, e);
        end
      end
      rd_en = 1'b1;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", wd);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++)
      r = ((r[0] ^ d[i]) != 1'b0) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic raw(input logic b);
    @(negedge clk); rx_bit = b; rx_valid = 1'b1;
  endtask
  task automatic quiet(input int n);
    @(negedge clk); rx_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask
  task automatic dbit(input logic b);
    raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask
  task automatic flag();
    for (int i = 0; i < 8; i++) raw(((8'h7E >> i) & 1) != 0);
    tx_ones = 0;
  endtask
  task automatic open_frame();
    flag(); tx_crc = 16'hFFFF;
  endtask
  task automatic put_byte(input logic [7:0] b, input bit store, input bit last);
    for (int i = 0; i < 8; i++) dbit(b[i]);
    tx_crc = crc_byte(tx_crc, b);
    if (store) exp_q.push_back({last, b});
  endtask
  task automatic close_frame(input bit bad, input int extra, input bit store);
    logic [15:0] f;
    f = ~tx_crc;
    if (bad) f = f ^ 16'h0001;
    put_byte(f[7:0], store, 1'b0);
    put_byte(f[15:8], store, 1'b1);
    for (int i = 0; i < extra; i++) dbit(i[0]);
    flag();
    for (int i = 0; i < 10; i++) raw(1'b1);
    quiet(6);
  endtask
  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int n,
                       input logic [7:0] seed, input bit store);
    open_frame();
    put_byte(b0, store, 1'b0);
    put_byte(b1, store, 1'b0);
    for (int i = 0; i < n; i++) put_byte(seed + 8'(i), store, 1'b0);
    close_frame(1'b0, 0, store);
  endtask
  task automatic drain();
    mon_en = 1'b1;
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rd_count == 0 && exp_q.size() == 0, "R8 drained", rd_count, 0);
  endtask
  task automatic clear_ev();
    @(negedge clk); ev_rd = 1'b1;
    @(negedge clk); ev_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(rd_count == 0 && !byte_avail, "R13 empty", rd_count, 0);
    chk(ev_flags == 0 && hit_slot == 0, "R13 events", ev_flags, 0);
    chk(irq == 0, "R13 irq", irq, 0);
    for (int i = 0; i < 16; i++) raw(1'b1);

    // R7 filtering off, R8 visibility only after closing flag
    open_frame();
    put_byte(8'h11, 1, 0); put_byte(8'h22, 1, 0); put_byte(8'h33, 1, 0);
    put_byte(8'h44, 1, 0);
    quiet(5);
    chk(rd_count == 0 && !byte_avail, "R8 uncommitted hidden", rd_count, 0);
    close_frame(0, 0, 1);
    chk(ev_flags == 6'h20, "R7 end-of-address only, R5 no idle abort", ev_flags, 6'h20);
    drain();
    clear_ev();
    chk(ev_flags == 0, "R12 read clears", ev_flags, 0);

    // R2 stuffed zeros removed
    open_frame();
    put_byte(8'hFF, 1, 0); put_byte(8'hFF, 1, 0); put_byte(8'h7E, 1, 0);
    put_byte(8'h3F, 1, 0); put_byte(8'hFC, 1, 0);
    close_frame(0, 0, 1);
    chk(ev_flags == 6'h20, "R2 clean frame with many ones", ev_flags, 6'h20);
    drain(); clear_ev();

    // R1 closing flag reused as opening, extra flags between frames
    open_frame();
    put_byte(8'hA1, 1, 0); put_byte(8'hA2, 1, 0); put_byte(8'hA3, 1, 0);
    begin
      logic [15:0] f; f = ~tx_crc;
      put_byte(f[7:0], 1, 0); put_byte(f[15:8], 1, 1);
    end
    flag(); flag();
    tx_crc = 16'hFFFF;
    put_byte(8'hB1, 1, 0); put_byte(8'hB2, 1, 0); put_byte(8'hB3, 1, 0);
    close_frame(0, 0, 1);
    chk(ev_flags == 6'h20, "R1 two frames no errors", ev_flags, 6'h20);
    drain(); clear_ev();

    // R3 FCS error, octets still delivered
    open_frame();
    put_byte(8'h01, 1, 0); put_byte(8'h02, 1, 0); put_byte(8'h03, 1, 0);
    close_frame(1, 0, 1);
    chk(ev_flags == 6'h24, "R3 fcs error", ev_flags, 6'h24);
    drain(); clear_ev();

    // R4 partial octet
    open_frame();
    put_byte(8'h05, 1, 0); put_byte(8'h06, 1, 0); put_byte(8'h07, 1, 0);
    close_frame(0, 3, 1);
    chk(ev_flags == 6'h22, "R4 partial octet", ev_flags, 6'h22);
    drain(); clear_ev();

    // R5 abort discards partial frame
    mon_en = 1'b0;
    open_frame();
    put_byte(8'h09, 0, 0); put_byte(8'h0A, 0, 0); put_byte(8'h0B, 0, 0);
    for (int i = 0; i < 12; i++) raw(1'b1);
    quiet(6);
    chk(ev_flags[0] == 1'b1, "R5 abort flagged", ev_flags, 6'h21);
    chk(rd_count == 0, "R5 abort rolled back", rd_count, 0);
    clear_ev();

    // R6 filtering on with slot priority
    mon_en = 1'b1;
    addr_dec_en = 1'b1;
    slot_en = 4'b1110;
    slot_addr = {16'hBEEF, 16'h4321, 16'h4321, 16'h1111};
    frame(8'h21, 8'h43, 1, 8'h55, 1);
    chk(hit_slot == 2'd1, "R6 lowest slot", hit_slot, 1);
    chk(ev_flags == 6'h20, "R6 valid address", ev_flags, 6'h20);
    drain(); clear_ev();
    frame(8'h11, 8'h11, 1, 8'h66, 0);
    chk(ev_flags == 0 && rd_count == 0, "R6 disabled slot rejects", ev_flags, 0);
    frame(8'hEF, 8'hBE, 2, 8'h70, 1);
    chk(hit_slot == 2'd3, "R6 slot three", hit_slot, 3);
    drain(); clear_ev();
    addr_dec_en = 1'b0;

    // R9 threshold interrupt
    mon_en = 1'b0;
    fifo_thresh = 6'd4;
    irq_en = 7'h40;
    frame(8'h31, 8'h32, 1, 8'h33, 1);
    chk(rd_count == 5, "R9 count", rd_count, 5);
    chk(irq == 1'b1, "R9 threshold irq", irq, 1);
    drain();
    chk(irq == 1'b0, "R9 below threshold", irq, 0);
    fifo_thresh = 6'd0;
    clear_ev();

    // R12 masking
    irq_en = 7'h00;
    open_frame();
    put_byte(8'h41, 1, 0); put_byte(8'h42, 1, 0); put_byte(8'h43, 1, 0);
    close_frame(1, 0, 1);
    drain();
    chk(irq == 1'b0, "R12 masked", irq, 0);
    irq_en = 7'h04;
    @(negedge clk);
    chk(irq == 1'b1, "R12 enabled", irq, 1);
    clear_ev();
    chk(irq == 1'b0, "R12 cleared", irq, 0);
    irq_en = 7'h00;

    // R10 overflow
    mon_en = 1'b0;
    frame(8'h50, 8'h51, 38, 8'h00, 0);
    chk(ev_flags[3] == 1'b1, "R10 overflow", ev_flags, 6'h28);
    chk(rd_count == 0, "R10 frame discarded", rd_count, 0);
    clear_ev();

    // R11 frame lost on a full queue
    frame(8'h60, 8'h61, 28, 8'h80, 1);
    chk(rd_count == 32, "R11 queue full", rd_count, 32);
    clear_ev();
    frame(8'h70, 8'h71, 3, 8'h90, 0);
    chk(ev_flags[4] == 1'b1 && ev_flags[3] == 1'b0, "R11 lost", ev_flags, 6'h30);
    chk(rd_count == 32, "R11 content kept", rd_count, 32);
    drain(); clear_ev();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule